// File: doc/BRIEF.md
# Static Branch Policy Scorer

This block watches the stream of retired instructions and scores three fixed branch prediction policies against what each conditional branch really did. The policies are: predict every branch not taken, predict every branch taken, and predict taken only for branches that jump to a lower or equal address. For each retired instruction the core supplies four things: its program counter, the program counter of the instruction that actually executed next, the address the instruction would jump to if taken, and two flags marking it as a control transfer and as conditional.

The block keeps saturating counts of:
- retired instructions;
- conditional branches;
- taken branches;
- not-taken branches;
- correct predictions for each of the three policies.

Software or a reporting unit reads these counts and forms the branch fraction and the accuracy percentages from them. Each count reflects a retirement on the clock cycle after that retirement is presented.

Top module: `branch_policy_scorer`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is sampled low at a rising clock edge, every count is cleared to zero. All counts read zero on the cycle after reset is released.
- R2: Each cycle with `ret_valid` high adds one to the instruction count. A cycle with `ret_valid` low changes no count.
- R3: A retirement counts as a conditional branch only when `ret_is_ctrl` and `ret_is_cond` are both 1. A retirement with either flag at 0 adds to the instruction count only.
- R4: A branch counts as not taken exactly when `ret_next_pc` equals `ret_pc + 8` modulo 2^32. Otherwise it counts as taken. Each branch adds one to exactly one of the taken or not-taken counts.
- R5: A branch counts as backward when `ret_target` is less than or equal to `ret_pc` (unsigned compare). The backward-taken policy scores a correct prediction when a backward branch is taken, or when a forward branch is not taken.
- R6: The always-taken policy scores a correct prediction on every taken branch. The always-not-taken policy scores a correct prediction on every not-taken branch.
- R7: Every count is `COUNT_W` bits wide (default 32). A count that reaches its maximum value holds there.
- R8: While the branch count is below its maximum, two sums equal the branch count: taken plus not-taken, and always-taken-correct plus always-not-taken-correct.
- R9: A count changes on the rising edge that samples the retirement, so the new value is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | ADDR_W | Address of the retiring instruction |
| ret_next_pc | input | ADDR_W | Address of the instruction executed next |
| ret_target | input | ADDR_W | Jump address if the branch were taken |
| ret_is_ctrl | input | 1 | Instruction is a control transfer |
| ret_is_cond | input | 1 | Instruction is conditional |
| cnt_insn | output | COUNT_W | Retired instruction count |
| cnt_branch | output | COUNT_W | Conditional branch count |
| cnt_taken | output | COUNT_W | Taken branch count |
| cnt_not_taken | output | COUNT_W | Not-taken branch count |
| cnt_ok_taken | output | COUNT_W | Correct predictions, always-taken policy |
| cnt_ok_not_taken | output | COUNT_W | Correct predictions, always-not-taken policy |
| cnt_ok_btfn | output | COUNT_W | Correct predictions, backward-taken policy |

## Verification
The assertions check these properties on every cycle:
- the increment-by-one and hold behaviour of the instruction count under valid and idle cycles;
- that non-branch retirements leave the branch count alone;
- that the backward-taken score follows the address compare;
- that saturated counts stay saturated;
- that the two sum invariants hold.

Other behaviours need the bench's scenarios:
- the exact classification of each stimulus, including the next-address wrap at the top of the address space, a target equal to the PC, and a next address that is a short step but not eight bytes;
- full saturation on a narrow-width instance;
- reset clearing counts in the middle of a run.

// File: rtl/bps_pkg.sv
// Package: shared constants for the branch policy scorer.
// Assumes one retirement per cycle at most.
package bps_pkg;
    // Index of each count inside the counter bank
    localparam int IDX_INSN      = 0;
    localparam int IDX_BRANCH    = 1;
    localparam int IDX_TAKEN     = 2;
    localparam int IDX_NOT_TAKEN = 3;
    localparam int IDX_OK_TAKEN  = 4;
    localparam int IDX_OK_NT     = 5;
    localparam int IDX_OK_BTFN   = 6;
    localparam int NUM_COUNTS    = 7;

    // Per-retirement classification result
    typedef struct packed {
        logic is_branch;
        logic taken;
        logic backward;
    } bps_class_t;
endpackage

// File: rtl/bps_classify.sv
// Module: bps_classify
// Purely combinational. Decides whether a retirement is a conditional
// branch, whether it was taken (next address differs from pc + INSN_BYTES)
// and whether it points backward (target <= pc).
// Assumes addresses wrap modulo 2^ADDR_W.
module bps_classify
    import bps_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 8
) (
    input  logic              is_ctrl,
    input  logic              is_cond,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] target,
    output bps_class_t        cls
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] fall_through;

    // Sequential successor address, wrapping at the top of the space
    always_comb fall_through = pc + STEP;

    // Classification of the retiring instruction
    always_comb begin
        cls.is_branch = is_ctrl & is_cond;
        cls.taken     = (next_pc != fall_through);
        cls.backward  = (target <= pc);
    end
endmodule

// File: rtl/bps_score.sv
// Module: bps_score
// Turns one classification into the increment request for each count.
// Assumes the valid qualifier covers the whole retirement.
module bps_score
    import bps_pkg::*;
(
    input  logic                  valid,
    input  bps_class_t            cls,
    output logic [NUM_COUNTS-1:0] inc
);
    logic br;

    // Qualified branch strobe
    always_comb br = valid & cls.is_branch;

    // Increment request per count
    always_comb begin
        inc                = '0;
        inc[IDX_INSN]      = valid;
        inc[IDX_BRANCH]    = br;
        inc[IDX_TAKEN]     = br &  cls.taken;
        inc[IDX_NOT_TAKEN] = br & ~cls.taken;
        inc[IDX_OK_TAKEN]  = br &  cls.taken;
        inc[IDX_OK_NT]     = br & ~cls.taken;
        inc[IDX_OK_BTFN]   = br & ~(cls.taken ^ cls.backward);
    end
endmodule

// File: rtl/bps_sat_counter.sv
// Module: bps_sat_counter
// Up-counter that holds at its maximum value and clears on synchronous
// active-low reset. Assumes increments of one per cycle at most.
module bps_sat_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Count up unless already saturated
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (inc && value != TOP)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/branch_policy_scorer.sv
// Module: branch_policy_scorer (top)
// Scores always-not-taken, always-taken and backward-taken/forward-not-taken
// static policies on the retired instruction stream. Counts saturate.
// Assumes at most one retirement per cycle, presented with ret_valid.
module branch_policy_scorer
    import bps_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int COUNT_W    = 32,
    parameter int INSN_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic [ADDR_W-1:0]  ret_pc,
    input  logic [ADDR_W-1:0]  ret_next_pc,
    input  logic [ADDR_W-1:0]  ret_target,
    input  logic               ret_is_ctrl,
    input  logic               ret_is_cond,
    output logic [COUNT_W-1:0] cnt_insn,
    output logic [COUNT_W-1:0] cnt_branch,
    output logic [COUNT_W-1:0] cnt_taken,
    output logic [COUNT_W-1:0] cnt_not_taken,
    output logic [COUNT_W-1:0] cnt_ok_taken,
    output logic [COUNT_W-1:0] cnt_ok_not_taken,
    output logic [COUNT_W-1:0] cnt_ok_btfn
);
    bps_class_t            cls;
    logic [NUM_COUNTS-1:0] inc;
    logic [COUNT_W-1:0]    bank [NUM_COUNTS];

    bps_classify #(
        .ADDR_W    (ADDR_W),
        .INSN_BYTES(INSN_BYTES)
    ) u_classify (
        .is_ctrl(ret_is_ctrl),
        .is_cond(ret_is_cond),
        .pc     (ret_pc),
        .next_pc(ret_next_pc),
        .target (ret_target),
        .cls    (cls)
    );

    bps_score u_score (
        .valid(ret_valid),
        .cls  (cls),
        .inc  (inc)
    );

    for (genvar g = 0; g < NUM_COUNTS; g++) begin : g_cnt
        bps_sat_counter #(.WIDTH(COUNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc[g]),
            .value(bank[g])
        );
    end

    // Map the counter bank to named outputs
    always_comb begin
        cnt_insn         = bank[IDX_INSN];
        cnt_branch       = bank[IDX_BRANCH];
        cnt_taken        = bank[IDX_TAKEN];
        cnt_not_taken    = bank[IDX_NOT_TAKEN];
        cnt_ok_taken     = bank[IDX_OK_TAKEN];
        cnt_ok_not_taken = bank[IDX_OK_NT];
        cnt_ok_btfn      = bank[IDX_OK_BTFN];
    end
endmodule

// File: rtl/bps_checker.sv
// Module: bps_checker
// Cycle-level properties of branch_policy_scorer, attached with bind.
module bps_checker #(
    parameter int ADDR_W  = 32,
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_valid,
    input logic [ADDR_W-1:0]  ret_pc,
    input logic [ADDR_W-1:0]  ret_target,
    input logic               ret_is_ctrl,
    input logic               ret_is_cond,
    input logic               taken_now,
    input logic [COUNT_W-1:0] cnt_insn,
    input logic [COUNT_W-1:0] cnt_branch,
    input logic [COUNT_W-1:0] cnt_taken,
    input logic [COUNT_W-1:0] cnt_not_taken,
    input logic [COUNT_W-1:0] cnt_ok_taken,
    input logic [COUNT_W-1:0] cnt_ok_not_taken,
    input logic [COUNT_W-1:0] cnt_ok_btfn
);
    localparam logic [COUNT_W-1:0] TOP = {COUNT_W{1'b1}};

    logic [COUNT_W:0] sum_dir;
    logic [COUNT_W:0] sum_ok;
    logic             btfn_hit;

    // Reference sums and backward-taken hit from port values
    always_comb begin
        sum_dir  = {1'b0, cnt_taken} + {1'b0, cnt_not_taken};
        sum_ok   = {1'b0, cnt_ok_taken} + {1'b0, cnt_ok_not_taken};
        btfn_hit = ((ret_target <= ret_pc) == taken_now);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_insn == '0 && cnt_branch == '0 && cnt_ok_btfn == '0));

    // R2
    insn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (cnt_insn == $past(cnt_insn) + 1'b1) || ($past(cnt_insn) == TOP));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> ($stable(cnt_insn) && $stable(cnt_branch) && $stable(cnt_ok_btfn)));

    // R3
    nonbranch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !(ret_is_ctrl && ret_is_cond)) |=> ($stable(cnt_branch) && $stable(cnt_taken)));

    // R5
    btfn_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_is_ctrl && ret_is_cond && btfn_hit && cnt_ok_btfn != TOP)
        |=> cnt_ok_btfn == $past(cnt_ok_btfn) + 1'b1);

    // R7
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_insn == TOP) |=> (cnt_insn == TOP));

    // R8
    dir_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_branch != TOP) |-> (sum_dir == {1'b0, cnt_branch}));

    // R8
    ok_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_branch != TOP) |-> (sum_ok == {1'b0, cnt_branch}));
endmodule

bind branch_policy_scorer bps_checker #(
    .ADDR_W (ADDR_W),
    .COUNT_W(COUNT_W)
) u_bps_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .ret_valid       (ret_valid),
    .ret_pc          (ret_pc),
    .ret_target      (ret_target),
    .ret_is_ctrl     (ret_is_ctrl),
    .ret_is_cond     (ret_is_cond),
    .taken_now       (ret_next_pc != ret_pc + ADDR_W'(INSN_BYTES)),
    .cnt_insn        (cnt_insn),
    .cnt_branch      (cnt_branch),
    .cnt_taken       (cnt_taken),
    .cnt_not_taken   (cnt_not_taken),
    .cnt_ok_taken    (cnt_ok_taken),
    .cnt_ok_not_taken(cnt_ok_not_taken),
    .cnt_ok_btfn     (cnt_ok_btfn)
);

// File: tb/test_branch_policy_scorer.sv
module test_branch_policy_scorer;
    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] nxt;
        logic [31:0] tgt;
        logic        ctrl;
        logic        cond;
        logic        br;
        logic        tk;
        logic        bk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{32'h100,      32'h108, 32'h200,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h100,      32'h200, 32'h200,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'h300,      32'h200, 32'h200,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{32'h300,      32'h308, 32'h200,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h400,      32'h408, 32'h400,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h400,      32'h500, 32'h500,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h400,      32'h408, 32'h100,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0,        32'h8,   32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'hFFFFFFF8, 32'h0,   32'h10,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h1000,     32'h1004, 32'h2000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [31:0] ret_pc = '0, ret_next_pc = '0, ret_target = '0;
    logic        ret_is_ctrl = 1'b0, ret_is_cond = 1'b0;
    logic [31:0] c_insn, c_br, c_tk, c_nt, c_okt, c_oknt, c_okb;
    logic [3:0]  n_insn, n_br, n_tk, n_nt, n_okt, n_oknt, n_okb;

    int checks = 0, errors = 0;
    bit done = 0;
    int e_insn, e_br, e_tk, e_nt, e_okt, e_oknt, e_okb;

    always #10 clk = ~clk;

    branch_policy_scorer i_branch_policy_scorer (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_next_pc(ret_next_pc), .ret_target(ret_target),
        .ret_is_ctrl(ret_is_ctrl), .ret_is_cond(ret_is_cond),
        .cnt_insn(c_insn), .cnt_branch(c_br), .cnt_taken(c_tk),
        .cnt_not_taken(c_nt), .cnt_ok_taken(c_okt),
        .cnt_ok_not_taken(c_oknt), .cnt_ok_btfn(c_okb));

    branch_policy_scorer #(.COUNT_W(4)) i_branch_policy_scorer_narrow (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_next_pc(ret_next_pc), .ret_target(ret_target),
        .ret_is_ctrl(ret_is_ctrl), .ret_is_cond(ret_is_cond),
        .cnt_insn(n_insn), .cnt_branch(n_br), .cnt_taken(n_tk),
        .cnt_not_taken(n_nt), .cnt_ok_taken(n_okt),
        .cnt_ok_not_taken(n_oknt), .cnt_ok_btfn(n_okb));

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "insn", c_insn, e_insn);
        check(req, "branch", c_br, e_br);
        check(req, "taken", c_tk, e_tk);
        check(req, "not_taken", c_nt, e_nt);
        check(req, "ok_taken", c_okt, e_okt);
        check(req, "ok_not_taken", c_oknt, e_oknt);
        check(req, "ok_btfn", c_okb, e_okb);
        // R8 invariants
        check("R8", "taken+not_taken", c_tk + c_nt, c_br);
        check("R8", "ok sums", c_okt + c_oknt, c_br);
    endtask

    task automatic clear_model();
        e_insn = 0; e_br = 0; e_tk = 0; e_nt = 0; e_okt = 0; e_oknt = 0; e_okb = 0;
    endtask

    // Drive one retirement for one cycle; counts are sampled on the next negedge
    task automatic retire(input vec_t v);
        @(negedge clk);
        ret_valid = 1'b1; ret_pc = v.pc; ret_next_pc = v.nxt; ret_target = v.tgt;
        ret_is_ctrl = v.ctrl; ret_is_cond = v.cond;
        @(negedge clk);
        ret_valid = 1'b0;
        e_insn++;
        if (v.br) begin
            e_br++;
            if (v.tk) begin e_tk++; e_okt++; end
            else begin e_nt++; e_oknt++; end
            if (v.tk == v.bk) e_okb++;
        end
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Table walk: R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            retire(TABLE[i]);
            check_all($sformatf("R3/R4/R5/R6/R9 vec%0d", i));
        end

        // Idle cycles change nothing (R2), with junk on the other inputs
        @(negedge clk);
        ret_pc = 32'h40; ret_next_pc = 32'h999; ret_is_ctrl = 1'b1; ret_is_cond = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R2 idle");

        // Saturation on the 4-bit instance (R7)
        for (int i = 0; i < 20; i++) retire(TABLE[1]);
        check("R7", "narrow insn", n_insn, 15);
        check("R7", "narrow branch", n_br, 15);
        check("R7", "narrow taken", n_tk, 15);
        check("R7", "narrow not_taken", n_nt, 4);
        check_all("R7 wide");

        // Reset in mid-run clears everything (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        check_all("R1 midrun");
        check("R1", "narrow insn", n_insn, 0);
        retire(TABLE[2]);
        check_all("R9 after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule